// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is the serial front end of a small register file. It watches the SCL and SDA lines through a fast system clock and finds start and stop conditions. It answers only to its own 7-bit address. While selected, it moves bytes between the two-wire bus and a plain register read/write port. SDA is open-drain: the block never drives a high level. It only asserts a drive-low enable, and the board pull-up supplies the high level.

In a write transfer, the byte after the address is a command byte that loads an internal register pointer. Every byte after that is stored at the pointer. A read transfer carries no command byte and returns data starting at the pointer left by an earlier write. To read from a chosen location, the master first sends a pointer-only write and then a separate read, either after a stop or after a repeated start. After each data byte written or read, the pointer steps by one and wraps at the end of the register space. The system clock must run at least eight times faster than SCL.

Top module: `i2c_ptr_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and `reg_we` is 0, so the SDA line reads high.
- R2: A byte after a start whose upper seven bits (sent MSB first) equal 7'h0D is acknowledged: SDA is held low through the high phase of the ninth SCL pulse.
- R3: When the address differs from 7'h0D, the block ignores the whole transfer. It never drives SDA, issues no register write and leaves the pointer unchanged until the next start.
- R4: In a write, address bit 0 is 0. The low PTR_W bits of the first following byte load the pointer and that byte is acknowledged. Each later byte is acknowledged and stored at the pointer, and the pointer then increments.
- R5: The pointer wraps from the last register (2^PTR_W-1) to register 0, both on writes and on reads.
- R6: In a read, address bit 0 is 1. The block shifts out, MSB first and changing only while SCL is low, the register at the pointer, then increments the pointer. The master acknowledging with a low ninth bit requests the next register.
- R7: When the master leaves SDA high in the ninth bit of a read byte, the block releases SDA and drives nothing more until a start or a stop.
- R8: A repeated start, with no stop in between, restarts address decoding and keeps the pointer set by the write that came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | PTR_W | Register pointer, also the register port address |
| reg_we | output | 1 | One-cycle write strobe for the register port |
| reg_wdata | output | 8 | Byte to store at `reg_addr` while `reg_we` is high |
| reg_rdata | input | 8 | Register content at `reg_addr` (combinational read) |

## Verification
The bench goes after several corner cases; each is listed with what a faulty design would do:
- Pointer wrap: writes and reads that run across the top register boundary. A pointer that saturates, or skips its increment, returns stale bytes from the wrong registers.
- Foreign address: transfers sent to other addresses. An address comparator that is off by one bit, or that keeps decoding after a mismatch, would acknowledge or corrupt the register file.
- Master not-acknowledge: the bench keeps clocking after the master ends a read with a high ninth bit. A design that keeps shifting would pull SDA low for the next byte.
- Repeated start: the master turns a pointer write into a read without a stop. A design that loses the pointer, or that treats the second address byte as data, returns the wrong register.

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h0D,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic             reg_we,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WDATA, S_RDATA, S_SKIP} st_t;

  logic [2:0]       scl_q, sda_q;
  st_t              st;
  logic [3:0]       bitcnt;
  logic             in_ack, nack;
  logic [7:0]       rx, tx;
  logic [PTR_W-1:0] ptr;

  wire scl   = scl_q[1];
  wire scl_d = scl_q[2];
  wire sda   = sda_q[1];
  wire sda_d = sda_q[2];

  wire start_c = scl & scl_d & sda_d & ~sda;
  wire stop_c  = scl & scl_d & ~sda_d & sda;
  wire rise    = scl & ~scl_d;
  wire fall    = ~scl & scl_d;
  wire active  = (st != S_IDLE) && (st != S_SKIP);

  assign reg_addr = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      in_ack    <= 1'b0;
      nack      <= 1'b0;
      rx        <= '0;
      tx        <= '0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) ptr <= ptr + 1'b1;

      if (start_c) begin
        st     <= S_ADDR;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (active) begin
        if (rise) begin
          if (in_ack) nack <= sda;
          else if (bitcnt < 4'd8) begin
            rx     <= {rx[6:0], sda};
            bitcnt <= bitcnt + 4'd1;
          end
        end else if (fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            if (st == S_RDATA) begin
              if (nack) st <= S_SKIP;
              else begin
                tx     <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
              end
            end
          end else if (bitcnt == 4'd8) begin
            in_ack <= 1'b1;
            case (st)
              S_ADDR:
                if (rx[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  st     <= rx[0] ? S_RDATA : S_CMD;
                end else st <= S_SKIP;
              S_CMD: begin
                sda_oe <= 1'b1;
                ptr    <= rx[PTR_W-1:0];
                st     <= S_WDATA;
              end
              S_WDATA: begin
                sda_oe    <= 1'b1;
                reg_we    <= 1'b1;
                reg_wdata <= rx;
              end
              S_RDATA: begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (st == S_RDATA) begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_ptr_slave_chk.sv
module i2c_ptr_slave_chk #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe,
  input logic             reg_we,
  input logic [PTR_W-1:0] reg_addr
);

  // R1
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sda_oe && !reg_we));

  // R6: drive changes happen only while SCL is low
  a_r6_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R4
  a_r4_we_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R4
  a_r4_we_in_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_i);

  // R5: increment wraps in the pointer width
  a_r5_ptr_steps_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));

endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/i2c_ptr_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_ptr_slave_tb_top;
  localparam int PW = 4;
  localparam int NREG = 1 << PW;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe, reg_we;
  logic [PW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [NREG];
  logic [7:0] exp_m [NREG];
  logic [PW-1:0] exp_ptr = '0;
  int checks = 0, fails = 0, oe_cnt = 0, we_cnt = 0;

  wire sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_ptr_slave #(.PTR_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < NREG; i++) mem[i] <= 8'(i * 7 + 3);
    else if (reg_we) mem[reg_addr] <= reg_wdata;
    if (sda_oe) oe_cnt <= oe_cnt + 1;
    if (reg_we) we_cnt <= we_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic qp(); repeat (8) @(posedge clk); #1; endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b; qp(); scl_m = 1; qp(); s = sda_line; qp(); scl_m = 0; qp();
  endtask

  task automatic i2c_start();
    sda_m = 1; qp(); scl_m = 1; qp(); sda_m = 0; qp(); scl_m = 0; qp();
  endtask

  task automatic i2c_stop();
    sda_m = 0; qp(); scl_m = 1; qp(); sda_m = 1; qp(); qp();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(d[i], s);
    bit_io(1'b1, s);
    acked = !s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); d[i] = s; end
    bit_io(!mack, s);
  endtask

  task automatic addr_byte(input logic rd, input string tag);
    logic a;
    wr_byte({7'h0D, rd}, a);
    check(a, tag, a, 1);
  endtask

  task automatic ptr_byte(input logic [PW-1:0] p, input string tag);
    logic a;
    wr_byte(8'(p), a);
    check(a, tag, a, 1);
    exp_ptr = p;
  endtask

  task automatic do_write(input logic [PW-1:0] p, input int n, input string tag);
    logic a; logic [7:0] d;
    i2c_start(); addr_byte(1'b0, "R2 write address ack"); ptr_byte(p, "R4 pointer ack");
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      wr_byte(d, a);
      check(a, tag, a, 1);
      exp_m[exp_ptr] = d;
      exp_ptr = exp_ptr + 1'b1;
    end
    i2c_stop();
  endtask

  task automatic read_body(input int n, input string tag);
    logic [7:0] d; logic s; int oe0;
    addr_byte(1'b1, "R2 read address ack");
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n - 1, d);
      check(d == exp_m[exp_ptr], tag, d, exp_m[exp_ptr]);
      exp_ptr = exp_ptr + 1'b1;
    end
    check(!sda_oe, "R7 released after nack", sda_oe, 0);
    oe0 = oe_cnt;
    for (int i = 0; i < 8; i++) bit_io(1'b1, s);
    check(oe_cnt == oe0, "R7 silent after nack", oe_cnt - oe0, 0);
    i2c_stop();
  endtask

  task automatic do_read(input int n, input string tag);
    i2c_start(); read_body(n, tag);
  endtask

  task automatic set_ptr(input logic [PW-1:0] p);
    i2c_start(); addr_byte(1'b0, "R2 address ack"); ptr_byte(p, "R6 pointer set"); i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=expired exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic a; int oe0, we0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) exp_m[i] = 8'(i * 7 + 3);
    repeat (5) @(posedge clk); #1;
    rst_n = 1;
    repeat (4) @(posedge clk); #1;
    check(!sda_oe, "R1 sda_oe after reset", sda_oe, 0);
    check(!reg_we, "R1 reg_we after reset", reg_we, 0);
    check(sda_line, "R1 line high", sda_line, 1);

    set_ptr(4'h5);
    do_read(3, "R6 read initial contents");

    do_write(4'h2, 3, "R4 data ack");
    set_ptr(4'h2);
    do_read(3, "R4 written data read back");

    do_write(4'hE, 4, "R5 data ack across wrap");
    set_ptr(4'hE);
    do_read(4, "R5 wrap on read");
    set_ptr(4'hF);
    do_read(2, "R5 read wrap F to 0");

    oe0 = oe_cnt; we0 = we_cnt;
    i2c_start();
    wr_byte({7'h2A, 1'b0}, a); check(!a, "R3 foreign address not acked", a, 0);
    wr_byte(8'h03, a);         check(!a, "R3 foreign data not acked", a, 0);
    wr_byte(8'h5A, a);         check(!a, "R3 foreign data not acked", a, 0);
    i2c_stop();
    i2c_start();
    wr_byte({7'h0C, 1'b1}, a); check(!a, "R3 neighbour address not acked", a, 0);
    i2c_stop();
    check(oe_cnt == oe0, "R3 no drive on mismatch", oe_cnt - oe0, 0);
    check(we_cnt == we0, "R3 no write on mismatch", we_cnt - we0, 0);
    do_read(2, "R3 pointer kept after mismatch");

    i2c_start(); addr_byte(1'b0, "R8 address ack"); ptr_byte(4'h9, "R8 pointer ack");
    i2c_start(); read_body(3, "R8 repeated start read");

    for (int it = 0; it < 12; it++) begin
      do_write(PW'($urandom), 1 + int'($urandom % 4), "R4 random write ack");
      if (it % 2 == 0) begin
        set_ptr(PW'($urandom));
        do_read(1 + int'($urandom % 4), "R6 random read");
      end else begin
        i2c_start(); addr_byte(1'b0, "R8 address ack"); ptr_byte(PW'($urandom), "R8 pointer ack");
        i2c_start(); read_body(1 + int'($urandom % 4), "R8 random repeated start read");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule